// File: doc/BRIEF.md
# Microcoded memory-to-memory sequencer

This block is the control unit of a small eight-instruction machine. The machine has no registers that a program can name. Every operand is either a direct 16-bit memory address or, for the store-immediate instruction, a one-byte constant. A five-bit step counter runs each instruction through a fixed frame of 32 cycles. A per-step control decode drives the following:

- the program-counter increment and load,
- the address latch,
- the selection between program counter and latch on the address bus,
- the A/B operand registers,
- the instruction/flag register,
- the memory write strobe.

The block connects to a synchronous byte memory with one cycle of read latency, and to an external combinational ALU. It drives the ALU operands and operation code. It takes back a result byte and a flag.

After reset the program counter is 0000. The counter is 15 bits wide, so bit 15 of every fetch address is 0. Instructions are byte strings that start at the address the program counter holds. Multi-byte addresses are big-endian, high byte first. A two-operand instruction is laid out as: opcode, src high, src low, dest high, dest low, one pad byte (6 bytes). Store-immediate is laid out as: opcode, constant, dest high, dest low (4 bytes). A jump is laid out as: opcode, target high, target low, one pad byte (4 bytes).

Top module: `mem2mem_ctrl`

## Requirements
- R1: While rst_n is low, mem_we is 0 and mem_addr is 0000. The first frame after reset fetches its opcode from address 0000.
- R2: Every instruction takes exactly 32 cycles. In step 0 of each frame, mem_addr equals the address of the next instruction.
- R3: The opcodes are STR=0, MOV=1, ADD=2, SUB=3, NAND=4, DIV2=5, JF=6 and JMP=7. Two-operand instructions advance the program counter by 6, and STR, JF and JMP advance it by 4.
- R4: MOV writes [src] to dest and sets the flag when that value is 0. It drives alu_op=2 with alu_a=[src].
- R5: ADD (alu_op 4), SUB (alu_op 3), NAND (alu_op 5) and DIV2 (alu_op 7) present alu_a=[src] and alu_b=[dest]. They write alu_res to dest and load alu_flag into the flag. The bench ALU gives A+B with carry, A-B with borrow, A nand B with a zero flag, and A/2 with a zero flag.
- R6: STR writes its constant to dest through alu_op 0 (result = A) and leaves the flag unchanged.
- R7: JMP always loads the target into the program counter. JF loads it only when the flag is 1 and otherwise falls through to the next instruction.
- R8: A two-operand instruction writes exactly once, in step 9. STR writes exactly once, in step 5. Jumps never write, and mem_we is never high on two consecutive cycles.
- R9: The program counter is 15 bits. Bit 15 of a jump target is dropped, and bit 15 of every fetch address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address: program counter or address latch |
| mem_wdata | output | 8 | Write data, the ALU result |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, for the address driven one cycle earlier |
| alu_op | output | 4 | ALU operation code |
| alu_en | output | 1 | ALU result in use (write step) |
| alu_a | output | 8 | Operand A register |
| alu_b | output | 8 | Operand B register |
| alu_res | input | 8 | Combinational ALU result |
| alu_flag | input | 1 | Combinational ALU flag |

## Verification
The assertions take two things for granted. First, mem_rdata always returns the byte at the address driven in the previous cycle. Second, alu_res and alu_flag are a pure function of alu_op, alu_a and alu_b within the same cycle. The bench keeps to both conditions: its memory model registers reads on the clock edge, and its ALU is purely combinational. The test program keeps every address inside the modelled kilobyte, except bit 15 of one jump target, which is set on purpose. The program also does not modify its own code, so the instruction-level reference model can fetch from its own copy of the memory.

// File: rtl/mem2mem_ctrl.sv
module mem2mem_ctrl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [3:0]    alu_op,
  output logic          alu_en,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  input  logic [DW-1:0] alu_res,
  input  logic          alu_flag
);
  localparam int PCW = AW - 1;
  localparam logic [2:0] OP_STR  = 3'd0;
  localparam logic [2:0] OP_MOV  = 3'd1;
  localparam logic [2:0] OP_ADD  = 3'd2;
  localparam logic [2:0] OP_SUB  = 3'd3;
  localparam logic [2:0] OP_NAND = 3'd4;
  localparam logic [2:0] OP_DIV2 = 3'd5;
  localparam logic [2:0] OP_JMP  = 3'd7;

  logic [SW-1:0]  step;
  logic [PCW-1:0] pc;
  logic [2:0]     ir;
  logic           flag;
  logic [AW-1:0]  al;
  logic [DW-1:0]  ra, rb;

  logic pc_inc, pc_ld, sel_al, ld_ir, ld_alh, ld_all, ld_a, ld_b, al_from_b, we;

  wire is_str = (ir == OP_STR);
  wire is_jmp = (ir[2:1] == 2'b11);
  wire is_two = !is_str && !is_jmp;

  always_comb begin
    pc_inc = 1'b0; pc_ld = 1'b0; sel_al = 1'b0; ld_ir = 1'b0;
    ld_alh = 1'b0; ld_all = 1'b0; ld_a = 1'b0; ld_b = 1'b0;
    al_from_b = 1'b0; we = 1'b0;
    if (step == SW'(0)) begin
      pc_inc = 1'b1;
    end else if (step == SW'(1)) begin
      pc_inc = 1'b1; ld_ir = 1'b1;
    end else if (is_two) begin
      case (step)
        SW'(2): begin ld_alh = 1'b1; pc_inc = 1'b1; end
        SW'(3): begin ld_all = 1'b1; pc_inc = 1'b1; end
        SW'(4): begin ld_b = 1'b1; sel_al = 1'b1; end
        SW'(5): begin ld_a = 1'b1; pc_inc = 1'b1; end
        SW'(6): begin al_from_b = 1'b1; pc_inc = 1'b1; end
        SW'(7): sel_al = 1'b1;
        SW'(8): ld_b = 1'b1;
        SW'(9): begin sel_al = 1'b1; we = 1'b1; end
        default: ;
      endcase
    end else if (is_str) begin
      case (step)
        SW'(2): begin ld_a = 1'b1; pc_inc = 1'b1; end
        SW'(3): begin ld_alh = 1'b1; pc_inc = 1'b1; end
        SW'(4): ld_all = 1'b1;
        SW'(5): begin sel_al = 1'b1; we = 1'b1; end
        default: ;
      endcase
    end else begin
      case (step)
        SW'(2): begin ld_alh = 1'b1; pc_inc = 1'b1; end
        SW'(3): begin ld_all = 1'b1; pc_inc = 1'b1; end
        SW'(4): pc_ld = (ir == OP_JMP) || flag;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ir)
      OP_MOV:  alu_op = 4'd2;
      OP_ADD:  alu_op = 4'd4;
      OP_SUB:  alu_op = 4'd3;
      OP_NAND: alu_op = 4'd5;
      OP_DIV2: alu_op = 4'd7;
      default: alu_op = 4'd0;
    endcase
  end

  assign mem_addr  = sel_al ? al : {1'b0, pc};
  assign mem_we    = we;
  assign mem_wdata = alu_res;
  assign alu_en    = we;
  assign alu_a     = ra;
  assign alu_b     = rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      pc   <= '0;
      ir   <= '0;
      flag <= 1'b0;
      al   <= '0;
      ra   <= '0;
      rb   <= '0;
    end else begin
      step <= step + SW'(1);
      if (pc_ld)       pc <= al[PCW-1:0];
      else if (pc_inc) pc <= pc + PCW'(1);
      if (ld_ir) ir <= mem_rdata[2:0];
      if (we && !is_str) flag <= alu_flag;
      if (al_from_b)   al <= {rb, mem_rdata};
      else if (ld_alh) al[AW-1:DW] <= mem_rdata;
      else if (ld_all) al[DW-1:0] <= mem_rdata;
      if (ld_a) ra <= mem_rdata;
      if (ld_b) rb <= mem_rdata;
    end
  end
endmodule

module mem2mem_ctrl_chk #(
  parameter int AW  = 16,
  parameter int SW  = 5,
  parameter int PCW = 15
) (
  input logic           clk,
  input logic           rst_n,
  input logic [SW-1:0]  step,
  input logic [PCW-1:0] pc,
  input logic [2:0]     ir,
  input logic           flag,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr
);
  always_comb begin
    if (!rst_n) begin
      // R1
      reset_quiet_chk: assert (!mem_we);
    end
  end

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R9
  fetch_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == SW'(0)) |-> !mem_addr[AW-1]);

  // R7
  jf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == SW'(4) && ir == 3'd6 && !flag) |=> (pc == $past(pc)));

  // R6
  str_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step > SW'(1) && ir == 3'd0) |=> $stable(flag));
endmodule

bind mem2mem_ctrl mem2mem_ctrl_chk #(.AW(AW), .SW(SW), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .pc(pc), .ir(ir), .flag(flag),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_mem2mem_ctrl.sv
module test_mem2mem_ctrl;
  localparam int CLK_NS = 10;
  localparam int NFRAMES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, alu_a, alu_b, alu_res;
  logic [3:0]  alu_op;
  logic mem_we, alu_en, alu_flag;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] mm  [0:1023];
  int mpc = 0;
  bit mflag = 0;
  int ws;
  int exp_addr, exp_data, exp_op;
  string wtag;

  always #(CLK_NS/2) clk = ~clk;

  mem2mem_ctrl i_mem2mem_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .alu_op(alu_op), .alu_en(alu_en),
    .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res), .alu_flag(alu_flag)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  always_comb begin
    logic [8:0] t;
    t = 9'd0;
    alu_res = alu_a;
    alu_flag = 1'b0;
    case (alu_op)
      4'd2: begin alu_res = alu_a; alu_flag = (alu_a == 8'd0); end
      4'd3: begin t = {1'b0, alu_a} - {1'b0, alu_b}; alu_res = t[7:0]; alu_flag = t[8]; end
      4'd4: begin t = {1'b0, alu_a} + {1'b0, alu_b}; alu_res = t[7:0]; alu_flag = t[8]; end
      4'd5: begin alu_res = ~(alu_a & alu_b); alu_flag = (alu_res == 8'd0); end
      4'd7: begin alu_res = alu_a >> 1; alu_flag = (alu_res == 8'd0); end
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input int b0, input int b1, input int b2, input int b3);
    mem[a] = b0[7:0]; mem[a+1] = b1[7:0]; mem[a+2] = b2[7:0]; mem[a+3] = b3[7:0];
  endtask

  function automatic int rd(input int a);
    return int'(mm[a & 1023]);
  endfunction

  task automatic exec();
    int op, s, d, a, b, r;
    op = rd(mpc) & 7;
    ws = -1;
    if (op == 0) begin
      d = (rd(mpc+2) << 8) | rd(mpc+3);
      ws = 5; exp_addr = d; exp_data = rd(mpc+1); exp_op = 0; wtag = "R6";
      mm[d & 1023] = exp_data[7:0];
      mpc = mpc + 4;
    end else if (op >= 6) begin
      d = (rd(mpc+1) << 8) | rd(mpc+2);
      if (op == 7 || mflag) mpc = d & 32'h7FFF;
      else mpc = mpc + 4;
    end else begin
      s = (rd(mpc+1) << 8) | rd(mpc+2);
      d = (rd(mpc+3) << 8) | rd(mpc+4);
      a = rd(s); b = rd(d);
      case (op)
        1: begin r = a; mflag = (a == 0); exp_op = 2; wtag = "R4"; end
        2: begin r = a + b; mflag = (r > 255); exp_op = 4; wtag = "R5"; end
        3: begin r = a - b; mflag = (a < b); exp_op = 3; wtag = "R5"; end
        4: begin r = (~(a & b)) & 255; mflag = (r == 0); exp_op = 5; wtag = "R5"; end
        default: begin r = a >> 1; mflag = (r == 0); exp_op = 7; wtag = "R5"; end
      endcase
      ws = 9; exp_addr = d; exp_data = r & 255;
      mm[d & 1023] = exp_data[7:0];
      mpc = mpc + 6;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    put(12'h000, 8'h00, 8'h05, 8'h03, 8'h00);
    put(12'h004, 8'h00, 8'hFB, 8'h03, 8'h01);
    put(12'h008, 8'h02, 8'h03, 8'h00, 8'h03); put(12'h00C, 8'h01, 8'h00, 8'h06, 8'h80);
    put(12'h010, 8'h18, 8'h00, 8'h00, 8'hEE); put(12'h014, 8'h03, 8'h02, 8'h00, 8'h00);
    put(12'h018, 8'h03, 8'h03, 8'h00, 8'h03); put(12'h01C, 8'h01, 8'h00, 8'h06, 8'h00);
    put(12'h020, 8'h00, 8'h00, 8'h00, 8'h00);
    put(12'h022, 8'h01, 8'h03, 8'h02, 8'h03); put(12'h026, 8'h03, 8'h00, 8'h04, 8'h03);
    put(12'h02A, 8'h00, 8'h03, 8'h04, 8'h00);
    put(12'h02E, 8'h05, 8'h03, 8'h04, 8'h03); put(12'h032, 8'h05, 8'h00, 8'h05, 8'h03);
    put(12'h036, 8'h06, 8'h03, 8'h07, 8'h00);
    put(12'h03A, 8'h06, 8'h00, 8'h42, 8'h00);
    put(12'h03E, 8'h00, 8'hEE, 8'h03, 8'h08);
    put(12'h042, 8'h07, 8'h00, 8'h42, 8'h00);
    mem[12'h304] = 8'hF0;
    mem[12'h306] = 8'h01;
    for (int i = 0; i < 1024; i++) mm[i] = mem[i];

    repeat (3) @(negedge clk);
    #1;
    chk(mem_we == 1'b0, "R1 we in reset", mem_we, 0);
    chk(mem_addr == 16'h0000, "R1 addr in reset", mem_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mem_addr == 16'h0000, "R1 first fetch", mem_addr, 0);

    for (int c = 0; c < NFRAMES * 32; c++) begin
      int s;
      s = c % 32;
      if (s == 0) begin
        chk(mem_addr == mpc[15:0], "R2/R3 fetch address", mem_addr, mpc);
        chk(mem_addr[15] == 1'b0, "R9 fetch msb", mem_addr, mpc);
        exec();
      end
      if (s == ws) begin
        chk(mem_we == 1'b1, {wtag, " R8 write strobe"}, mem_we, 1);
        chk(mem_addr == exp_addr[15:0], {wtag, " write address"}, mem_addr, exp_addr);
        chk(mem_wdata == exp_data[7:0], {wtag, " write data"}, mem_wdata, exp_data);
        chk(alu_op == exp_op[3:0], {wtag, " alu op"}, alu_op, exp_op);
      end else begin
        chk(mem_we == 1'b0, "R8 stray write", mem_we, 0);
      end
      @(negedge clk);
      #1;
    end

    chk(mpc == 32'h42, "R7 halt loop reached", mpc, 32'h42);
    chk(mem[12'h300] == 8'h05, "R6 str const", mem[12'h300], 8'h05);
    chk(mem[12'h301] == 8'h05, "R5 sub after add", mem[12'h301], 8'h05);
    chk(mem[12'h302] == 8'h00, "R7 jf taken skips store", mem[12'h302], 8'h00);
    chk(mem[12'h303] == 8'h00, "R4 mov zero", mem[12'h303], 8'h00);
    chk(mem[12'h304] == 8'hFF, "R5 nand", mem[12'h304], 8'hFF);
    chk(mem[12'h305] == 8'h7F, "R5 div2", mem[12'h305], 8'h7F);
    chk(mem[12'h307] == 8'h00, "R5 div2 zero", mem[12'h307], 8'h00);
    chk(mem[12'h308] == 8'h00, "R7 jf after zero flag", mem[12'h308], 8'h00);
    for (int i = 12'h300; i < 12'h310; i++)
      chk(mem[i] == mm[i], "R3 final memory", mem[i], mm[i]);
    summary();
  end
endmodule